// File: doc/BRIEF.md
# SPI Chip-Select Sequencer with Guard Gap

This block owns the four active-low peripheral select lines of an SPI master. A transfer engine asks for a peripheral by presenting a 4-bit select code, together with a mode bit that chooses how the code is read. In priority mode the lowest zero bit of the code picks the one line to pull low. In pass-through mode the code is driven straight onto the lines. The engine later drops the select with a release strobe.

After every release the block holds all lines high for a guard gap before any line may go low again. This keeps two peripherals from driving the shared data line at the same moment. The gap is the 8-bit delay setting in master-clock cycles, with a floor of six cycles. A request that comes in during the gap is parked and `busy` stays high until it is applied. A request with the all-ones code is refused and flagged.

Top module: `cs_guard_seq`

## Requirements
- R1: Reset drives `cs_n` to 1111 with `busy` and `err_pulse` low, and clears the guard gap. The first legal request after reset drives its select in the very next cycle.
- R2: With `decode_en` low, any code whose bit 0 is 0 gives `cs_n` = 1110. Bits 3..1 have no effect.
- R3: With `decode_en` low, code bits [1:0] = 01 give 1101 and code bits [2:0] = 011 give 1011. The bits above have no effect.
- R4: With `decode_en` low, code 0111 gives `cs_n` = 0111.
- R5: With `decode_en` high, `cs_n` equals the 4-bit request code bit for bit.
- R6: Code 1111 is refused in either mode. `cs_n` stays 1111, `busy` stays low, and `err_pulse` is high for exactly the one cycle after the request.
- R7: When a select is active, `release_i` returns `cs_n` to 1111 and drops `busy` in the next cycle.
- R8: If `gap_cfg` is 6 or less at release, a new select goes low no earlier than 6 cycles after the lines went high. A request held in the gap is applied exactly at that point.
- R9: If `gap_cfg` is greater than 6 at release, the gap is `gap_cfg` cycles, with the same exact timing for a held request.
- R10: A legal request made during the gap raises `busy` in the next cycle. `busy` stays high while the request is held, and `cs_n` stays 1111 until the gap ends.
- R11: A request is taken only while `busy` is low. While a select is active, new requests do not change `cs_n`. `release_i` has no effect when no select is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Select request strobe |
| req_code | input | 4 | Peripheral select code |
| decode_en | input | 1 | 1 = pass-through mode, 0 = lowest-zero priority mode |
| gap_cfg | input | 8 | Guard gap setting in cycles, with a floor of 6 |
| release_i | input | 1 | Deassert the active select |
| busy | output | 1 | High while a select is active or a request is held |
| cs_n | output | 4 | Active-low chip-select lines |
| err_pulse | output | 1 | One-cycle flag for a refused code |

## Verification
A request or release presented before clock edge E has its effect on `cs_n`, `busy` and `err_pulse` just after E, because every output comes from a register. A request held in the gap after a release at edge E0 is applied just after edge E0+N, where N is the effective gap. The bench drives inputs on falling edges and samples on the falling edge after the edge of interest. It counts N−2 further falling edges after a back-to-back request to check the last high cycle, and one more to check the activation. A behavioural model tracks the cycles elapsed since each release rather than a down-counter, and is compared with the outputs on every falling edge.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_ACTIVE = 2'd1,
    SEQ_WAIT   = 2'd2
  } seq_state_t;

endpackage

// File: rtl/cs_code_decode.sv
module cs_code_decode #(
  parameter int NUM_CS = 4
) (
  input  logic [NUM_CS-1:0] code,
  input  logic              pass_mode,
  output logic [NUM_CS-1:0] pattern,
  output logic              legal
);

  localparam logic [NUM_CS-1:0] ALL_HIGH = '1;

  logic [NUM_CS-1:0] prio_pattern;
  logic              prio_hit;

  // Lowest zero wins: scanning downward lets the lowest index write last.
  always_comb begin
    prio_pattern = ALL_HIGH;
    prio_hit     = 1'b0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (!code[i]) begin
        prio_pattern    = ALL_HIGH;
        prio_pattern[i] = 1'b0;
        prio_hit        = 1'b1;
      end
    end
  end

  always_comb begin
    if (pass_mode) begin
      pattern = code;
      legal   = (code != ALL_HIGH);
    end else begin
      pattern = prio_pattern;
      legal   = prio_hit;
    end
  end

endmodule

// File: rtl/cs_gap_timer.sv
module cs_gap_timer #(
  parameter int CFG_W   = 8,
  parameter int MIN_GAP = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] gap_cfg,
  output logic             gap_clear
);

  localparam logic [CFG_W-1:0] FLOOR = CFG_W'(MIN_GAP);

  logic [CFG_W-1:0] cnt_q, cnt_d, load_val;
  logic             cnt_en;

  always_comb begin
    load_val = (gap_cfg <= FLOOR) ? FLOOR : gap_cfg;
    cnt_en   = load || (cnt_q != '0);
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  // A count of 1 means the coming edge is the last one of the gap.
  assign gap_clear = (cnt_q <= CFG_W'(1));

endmodule

// File: rtl/cs_seq_ctrl.sv
module cs_seq_ctrl
  import cs_seq_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [NUM_CS-1:0] dec_pattern,
  input  logic              dec_legal,
  input  logic              release_i,
  input  logic              gap_clear,
  output logic              gap_load,
  output logic              busy,
  output logic [NUM_CS-1:0] cs_n,
  output logic              err_pulse
);

  localparam logic [NUM_CS-1:0] ALL_HIGH = '1;

  seq_state_t        state_q, state_d;
  logic [NUM_CS-1:0] cs_q, cs_d, pend_q, pend_d;
  logic              cs_en, pend_en, err_q, err_d;

  always_comb begin
    state_d  = state_q;
    cs_d     = cs_q;
    cs_en    = 1'b0;
    pend_d   = pend_q;
    pend_en  = 1'b0;
    err_d    = 1'b0;
    gap_load = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (req_valid) begin
          if (!dec_legal) begin
            err_d = 1'b1;
          end else if (gap_clear) begin
            cs_d    = dec_pattern;
            cs_en   = 1'b1;
            state_d = SEQ_ACTIVE;
          end else begin
            pend_d  = dec_pattern;
            pend_en = 1'b1;
            state_d = SEQ_WAIT;
          end
        end
      end
      SEQ_WAIT: begin
        if (gap_clear) begin
          cs_d    = pend_q;
          cs_en   = 1'b1;
          state_d = SEQ_ACTIVE;
        end
      end
      SEQ_ACTIVE: begin
        if (release_i) begin
          cs_d     = ALL_HIGH;
          cs_en    = 1'b1;
          gap_load = 1'b1;
          state_d  = SEQ_IDLE;
        end
      end
      default: begin
        state_d = SEQ_IDLE;
        cs_d    = ALL_HIGH;
        cs_en   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cs_q <= ALL_HIGH;
    else if (cs_en)
      cs_q <= cs_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend_q <= ALL_HIGH;
    else if (pend_en)
      pend_q <= pend_d;
  end

  assign busy      = (state_q != SEQ_IDLE);
  assign cs_n      = cs_q;
  assign err_pulse = err_q;

endmodule

// File: rtl/cs_guard_seq.sv
module cs_guard_seq #(
  parameter int NUM_CS  = 4,
  parameter int CFG_W   = 8,
  parameter int MIN_GAP = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [NUM_CS-1:0] req_code,
  input  logic              decode_en,
  input  logic [CFG_W-1:0]  gap_cfg,
  input  logic              release_i,
  output logic              busy,
  output logic [NUM_CS-1:0] cs_n,
  output logic              err_pulse
);

  logic [NUM_CS-1:0] dec_pattern;
  logic              dec_legal, gap_clear, gap_load;

  cs_code_decode #(.NUM_CS(NUM_CS)) u_decode (
    .code      (req_code),
    .pass_mode (decode_en),
    .pattern   (dec_pattern),
    .legal     (dec_legal)
  );

  cs_gap_timer #(.CFG_W(CFG_W), .MIN_GAP(MIN_GAP)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (gap_load),
    .gap_cfg   (gap_cfg),
    .gap_clear (gap_clear)
  );

  cs_seq_ctrl #(.NUM_CS(NUM_CS)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .dec_pattern (dec_pattern),
    .dec_legal   (dec_legal),
    .release_i   (release_i),
    .gap_clear   (gap_clear),
    .gap_load    (gap_load),
    .busy        (busy),
    .cs_n        (cs_n),
    .err_pulse   (err_pulse)
  );

endmodule

// File: rtl/cs_guard_seq_chk.sv
module cs_guard_seq_chk #(
  parameter int NUM_CS  = 4,
  parameter int CFG_W   = 8,
  parameter int MIN_GAP = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [NUM_CS-1:0] req_code,
  input logic [CFG_W-1:0]  gap_cfg,
  input logic              release_i,
  input logic              busy,
  input logic [NUM_CS-1:0] cs_n,
  input logic              err_pulse
);

  localparam logic [NUM_CS-1:0] ALL_HIGH = '1;
  localparam int               RUN_W    = CFG_W + 1;

  logic [RUN_W-1:0] high_run, need_q;
  logic             seen_rel;

  // Cycles the lines have spent all high, and the gap owed since the last release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_run <= '0;
      need_q   <= '0;
      seen_rel <= 1'b0;
    end else begin
      if (cs_n == ALL_HIGH) begin
        if (high_run != '1) high_run <= high_run + 1'b1;
      end else begin
        high_run <= '0;
      end
      if (release_i && cs_n != ALL_HIGH) begin
        seen_rel <= 1'b1;
        need_q   <= (gap_cfg <= CFG_W'(MIN_GAP)) ? RUN_W'(MIN_GAP) : RUN_W'(gap_cfg);
      end
    end
  end

  assert_release_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i && cs_n != ALL_HIGH) |=> (cs_n == ALL_HIGH && !busy));

  assert_refused_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_code == ALL_HIGH) |=> (err_pulse && cs_n == ALL_HIGH && !busy));

  assert_gap_respected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_rel && cs_n != ALL_HIGH && $past(cs_n) == ALL_HIGH) |-> (high_run >= need_q));

  assert_busy_after_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_code != ALL_HIGH) |=> busy);

  assert_active_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cs_n != ALL_HIGH) |=> (cs_n == $past(cs_n) || cs_n == ALL_HIGH));

endmodule

bind cs_guard_seq cs_guard_seq_chk #(
  .NUM_CS(NUM_CS), .CFG_W(CFG_W), .MIN_GAP(MIN_GAP)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_code  (req_code),
  .gap_cfg   (gap_cfg),
  .release_i (release_i),
  .busy      (busy),
  .cs_n      (cs_n),
  .err_pulse (err_pulse)
);

// File: tb/cs_guard_seq_bench.sv
module cs_guard_seq_bench;

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic [3:0] req_code;
  logic       decode_en;
  logic [7:0] gap_cfg;
  logic       release_i;
  logic       busy;
  logic [3:0] cs_n;
  logic       err_pulse;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  cs_guard_seq u_cs_guard_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_code  (req_code),
    .decode_en (decode_en),
    .gap_cfg   (gap_cfg),
    .release_i (release_i),
    .busy      (busy),
    .cs_n      (cs_n),
    .err_pulse (err_pulse)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Behavioural reference: counts edges elapsed since the last release.
  int         m_state;
  logic [3:0] m_cs, m_pend;
  logic       m_err;
  int         m_since, m_need;

  function automatic logic [3:0] ref_decode(input logic [3:0] c, input logic pass);
    if (pass) return c;
    casez (c)
      4'b???0: return 4'b1110;
      4'b??01: return 4'b1101;
      4'b?011: return 4'b1011;
      4'b0111: return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_cs = 4'hF; m_pend = 4'hF; m_err = 0; m_since = 1000; m_need = 0;
    end else begin
      bit allowed;
      allowed = (m_since + 1 >= m_need);
      m_err   = 0;
      if (m_since < 1000) m_since = m_since + 1;
      case (m_state)
        0: if (req_valid) begin
             if (req_code == 4'hF) m_err = 1;
             else if (allowed) begin m_cs = ref_decode(req_code, decode_en); m_state = 1; end
             else begin m_pend = ref_decode(req_code, decode_en); m_state = 2; end
           end
        2: if (allowed) begin m_cs = m_pend; m_state = 1; end
        default: if (release_i) begin
             m_cs = 4'hF; m_state = 0; m_since = 0;
             m_need = (gap_cfg <= 8'd6) ? 6 : int'(gap_cfg);
           end
      endcase
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("MODEL cs_n", {4'h0, cs_n}, {4'h0, m_cs});
      check("MODEL busy", {7'h0, busy}, {7'h0, (m_state != 0)});
      check("MODEL err_pulse", {7'h0, err_pulse}, {7'h0, m_err});
    end
  end

  // Tasks start just after a falling edge and return one falling edge later.
  task automatic do_req(input logic [3:0] c, input logic pass);
    req_valid = 1'b1; req_code = c; decode_en = pass;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_rel(input logic [7:0] g);
    release_i = 1'b1; gap_cfg = g;
    @(negedge clk);
    release_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_code = 4'h0; decode_en = 1'b0;
    gap_cfg = 8'd0; release_i = 1'b0;
    idle(3);
    rst_n = 1'b1;
    check("R1 reset cs_n", {4'h0, cs_n}, 8'h0F);
    check("R1 reset busy", {7'h0, busy}, 8'h00);
    check("R1 reset err", {7'h0, err_pulse}, 8'h00);

    do_req(4'b1010, 1'b0);
    check("R1 R2 first request immediate", {4'h0, cs_n}, 8'h0E);
    check("R10 busy while active", {7'h0, busy}, 8'h01);
    do_req(4'b0011, 1'b0);
    check("R11 request while busy ignored", {4'h0, cs_n}, 8'h0E);

    do_rel(8'd3);
    check("R7 release cs_n", {4'h0, cs_n}, 8'h0F);
    check("R7 release busy", {7'h0, busy}, 8'h00);
    do_req(4'b1101, 1'b0);
    check("R10 held busy", {7'h0, busy}, 8'h01);
    idle(4);
    check("R8 last gap cycle", {4'h0, cs_n}, 8'h0F);
    check("R10 still busy", {7'h0, busy}, 8'h01);
    idle(1);
    check("R8 R3 applied after 6", {4'h0, cs_n}, 8'h0D);

    do_rel(8'd10);
    do_req(4'b0011, 1'b0);
    idle(8);
    check("R9 last gap cycle", {4'h0, cs_n}, 8'h0F);
    idle(1);
    check("R9 R3 applied after 10", {4'h0, cs_n}, 8'h0B);

    do_rel(8'd6);
    idle(10);
    do_rel(8'd6);
    check("R11 release when idle ignored", {4'h0, cs_n}, 8'h0F);
    check("R11 release idle busy", {7'h0, busy}, 8'h00);
    do_req(4'b0111, 1'b0);
    check("R4 code 0111", {4'h0, cs_n}, 8'h07);

    do_rel(8'd7);
    do_req(4'b1111, 1'b0);
    check("R6 refused cs_n", {4'h0, cs_n}, 8'h0F);
    check("R6 refused err", {7'h0, err_pulse}, 8'h01);
    check("R6 refused busy", {7'h0, busy}, 8'h00);
    idle(1);
    check("R6 err one cycle", {7'h0, err_pulse}, 8'h00);
    do_req(4'b0110, 1'b1);
    idle(3);
    check("R9 gap 7 last cycle", {4'h0, cs_n}, 8'h0F);
    idle(1);
    check("R5 R9 pass-through after 7", {4'h0, cs_n}, 8'h06);

    do_rel(8'd0);
    idle(8);
    do_req(4'b1111, 1'b1);
    check("R6 refused in pass mode", {7'h0, err_pulse}, 8'h01);
    do_req(4'b1000, 1'b0);
    check("R2 high bits ignored", {4'h0, cs_n}, 8'h0E);
    do_rel(8'd2);
    idle(8);
    do_req(4'b0101, 1'b0);
    check("R3 code 0101", {4'h0, cs_n}, 8'h0D);
    do_rel(8'd2);
    idle(8);
    do_req(4'b1010, 1'b1);
    check("R5 pass-through 1010", {4'h0, cs_n}, 8'h0A);
    do_rel(8'd2);
    idle(2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule